// File: doc/BRIEF.md
# Lockstep Subtractive GCD Pair

This block computes the greatest common divisor of two positive unsigned operands with two different datapaths that run side by side on the same operand pair. The paired engine has two subtractors. Each productive cycle, it removes the smaller value from the larger one. The single engine has one subtractor. It always computes its first value minus its second value. When that difference would be negative, it exchanges the two values instead of subtracting, which costs it an extra cycle.

To keep the two engines in step, the paired engine carries an orientation bit. It views its own pair through that bit and, on exactly the cycles where the single engine exchanges its values, it freezes its values and flips the bit. The single engine carries a history bit that flips on every exchange. With these two bits, a fixed multiplexer mapping links the two state tuples on every cycle. Both engines also finish in the same cycle.

A one-cycle start strobe loads both engines; a done level and the result follow. Debug ports expose both state tuples, so the mapping can be observed from outside. Operands of zero and signed operands are outside the intended use.

Top module: `gcd_lockstep`

## Requirements
- R1: A start strobe sampled at a clock edge loads op_p into dbg_x and dbg_a and op_q into dbg_y and dbg_b, and clears dbg_c and dbg_s. The loaded values are visible in the next cycle, and a start always takes effect, even while a computation is running.
- R2: On a running cycle of the single engine (dbg_a != dbg_b) with no start, if dbg_a < dbg_b the engine exchanges dbg_a and dbg_b and inverts dbg_s. Otherwise it replaces dbg_a with dbg_a - dbg_b and keeps dbg_s.
- R3: On a running cycle of the paired engine (dbg_x != dbg_y) with no start, it forms the mapped pair p = dbg_c ? dbg_y : dbg_x and q = dbg_c ? dbg_x : dbg_y. If p < q, it holds dbg_x and dbg_y and inverts dbg_c. Otherwise it replaces the larger of dbg_x and dbg_y by their difference and keeps dbg_c.
- R4: On every cycle after reset, dbg_a == (dbg_c ? dbg_y : dbg_x), dbg_b == (dbg_c ? dbg_x : dbg_y), and dbg_s == dbg_c.
- R5: After reset, done is 0 and all debug values and the result are 0. After a load, done is 1 exactly when the held values are equal, result carries that common value, and both engines report completion in the same cycle.
- R6: Once done is 1 and no start arrives, done, result and both state tuples hold their values.
- R7: For op_p = 4 and op_q = 6, (dbg_x, dbg_y, dbg_c) on the cycles after the load is (4,6,0), (4,6,1), (4,2,1), (4,2,0), (2,2,0).
- R8: For op_p = 4 and op_q = 6, (dbg_a, dbg_b, dbg_s) on the same cycles is (4,6,0), (6,4,1), (2,4,1), (4,2,0), (2,2,0).
- R9: The number of cycles from the load to done equals the number of exchange and subtract steps of the single-engine rule. Equal operands raise done in the first cycle after the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load strobe for both engines |
| op_p | input | W | First operand |
| op_q | input | W | Second operand |
| done | output | 1 | Values have converged since the last load |
| result | output | W | Greatest common divisor when done is 1 |
| dbg_x | output | W | Paired engine, first value |
| dbg_y | output | W | Paired engine, second value |
| dbg_c | output | 1 | Paired engine orientation bit |
| dbg_a | output | W | Single engine, first value |
| dbg_b | output | W | Single engine, second value |
| dbg_s | output | 1 | Single engine history bit |

## Verification
The bench follows the 4 and 6 case tuple by tuple. It also runs pairs that start in the reversed order, equal pairs, coprime pairs and a long run against a divisor of 1, and it checks the mapping on every cycle.

Each corner case catches a different fault. A paired engine that decides its pause from its raw values instead of the mapped ones pauses on the wrong cycles, which breaks the mapping and the 4 and 6 trace. An engine that lets the orientation or history bit drift on subtract cycles shows up as a mapping mismatch. A done that rises one cycle late or early fails the step-count comparison for equal operands. A start issued in the middle of a long run must restart the computation; an engine that ignores it returns the stale result.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

    localparam int unsigned GCD_W_DEFAULT = 16;

    // per-cycle action of either engine
    typedef enum logic [1:0] {
        ACT_IDLE   = 2'd0,
        ACT_REDUCE = 2'd1,
        ACT_TURN   = 2'd2
    } act_e;

endpackage

// File: rtl/gcd_eng_pair.sv
module gcd_eng_pair
    import gcd_pkg::*;
#(
    parameter int unsigned W = GCD_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] in_p,
    input  logic [W-1:0] in_q,
    output logic [W-1:0] v0,
    output logic [W-1:0] v1,
    output logic         orient,
    output logic         fin
);

    logic         loaded_q;
    logic [W-1:0] view_p;
    logic [W-1:0] view_q;
    logic [W-1:0] diff_01;
    logic [W-1:0] diff_10;
    act_e         act;

    // view through the orientation bit, in the single engine's frame
    assign view_p  = orient ? v1 : v0;
    assign view_q  = orient ? v0 : v1;
    assign diff_01 = v0 - v1;
    assign diff_10 = v1 - v0;

    always_comb begin
        if (v0 == v1)             act = ACT_IDLE;
        else if (view_p < view_q) act = ACT_TURN;
        else                      act = ACT_REDUCE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v0       <= '0;
            v1       <= '0;
            orient   <= 1'b0;
            loaded_q <= 1'b0;
        end else if (load) begin
            v0       <= in_p;
            v1       <= in_q;
            orient   <= 1'b0;
            loaded_q <= 1'b1;
        end else begin
            unique case (act)
                ACT_TURN:   orient <= ~orient;
                ACT_REDUCE: begin
                    if (v0 > v1) v0 <= diff_01;
                    else         v1 <= diff_10;
                end
                default: ;
            endcase
        end
    end

    assign fin = loaded_q && (v0 == v1);

endmodule

// File: rtl/gcd_eng_single.sv
module gcd_eng_single
    import gcd_pkg::*;
#(
    parameter int unsigned W = GCD_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] in_p,
    input  logic [W-1:0] in_q,
    output logic [W-1:0] v0,
    output logic [W-1:0] v1,
    output logic         hist,
    output logic         fin
);

    logic         loaded_q;
    logic [W:0]   diff_ext;
    act_e         act;

    // one subtractor; its borrow decides between reduce and exchange
    assign diff_ext = {1'b0, v0} - {1'b0, v1};

    always_comb begin
        if (v0 == v1)       act = ACT_IDLE;
        else if (diff_ext[W]) act = ACT_TURN;
        else                act = ACT_REDUCE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v0       <= '0;
            v1       <= '0;
            hist     <= 1'b0;
            loaded_q <= 1'b0;
        end else if (load) begin
            v0       <= in_p;
            v1       <= in_q;
            hist     <= 1'b0;
            loaded_q <= 1'b1;
        end else begin
            unique case (act)
                ACT_TURN: begin
                    v0   <= v1;
                    v1   <= v0;
                    hist <= ~hist;
                end
                ACT_REDUCE: v0 <= diff_ext[W-1:0];
                default: ;
            endcase
        end
    end

    assign fin = loaded_q && (v0 == v1);

endmodule

// File: rtl/gcd_lockstep.sv
module gcd_lockstep
    import gcd_pkg::*;
#(
    parameter int unsigned W = GCD_W_DEFAULT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] op_p,
    input  logic [W-1:0] op_q,
    output logic         done,
    output logic [W-1:0] result,
    output logic [W-1:0] dbg_x,
    output logic [W-1:0] dbg_y,
    output logic         dbg_c,
    output logic [W-1:0] dbg_a,
    output logic [W-1:0] dbg_b,
    output logic         dbg_s
);

    logic fin_a;
    logic fin_b;

    gcd_eng_pair #(.W(W)) u_pair (
        .clk    (clk),
        .rst    (rst),
        .load   (start),
        .in_p   (op_p),
        .in_q   (op_q),
        .v0     (dbg_x),
        .v1     (dbg_y),
        .orient (dbg_c),
        .fin    (fin_a)
    );

    gcd_eng_single #(.W(W)) u_single (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .in_p (op_p),
        .in_q (op_q),
        .v0   (dbg_a),
        .v1   (dbg_b),
        .hist (dbg_s),
        .fin  (fin_b)
    );

    assign done   = fin_b;
    assign result = dbg_a;

endmodule

// File: rtl/gcd_lockstep_chk.sv
module gcd_lockstep_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [W-1:0] op_p,
    input logic [W-1:0] op_q,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] x,
    input logic [W-1:0] y,
    input logic         c,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic         s,
    input logic         fin_a,
    input logic         fin_b
);

    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        start |=> (x == $past(op_p) && a == $past(op_p) &&
                   y == $past(op_q) && b == $past(op_q) && !c && !s));

    a_r2_exchange: assert property (@(posedge clk) disable iff (rst)
        (!start && a < b) |=> (a == $past(b) && b == $past(a) && s != $past(s)));

    a_r3_pause: assert property (@(posedge clk) disable iff (rst)
        (!start && x != y && (c ? y : x) < (c ? x : y))
        |=> ($stable(x) && $stable(y) && c != $past(c)));

    a_r4_map_first: assert property (@(posedge clk) disable iff (rst)
        a == (c ? y : x));

    a_r4_map_second: assert property (@(posedge clk) disable iff (rst)
        b == (c ? x : y));

    a_r4_map_bit: assert property (@(posedge clk) disable iff (rst)
        s == c);

    a_r5_fin_lock: assert property (@(posedge clk) disable iff (rst)
        fin_a == fin_b);

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(result)));

endmodule

bind gcd_lockstep gcd_lockstep_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .op_p   (op_p),
    .op_q   (op_q),
    .done   (done),
    .result (result),
    .x      (dbg_x),
    .y      (dbg_y),
    .c      (dbg_c),
    .a      (dbg_a),
    .b      (dbg_b),
    .s      (dbg_s),
    .fin_a  (fin_a),
    .fin_b  (fin_b)
);

// File: tb/gcd_lockstep_test.sv
module gcd_lockstep_test;

    localparam int unsigned W = 16;
    localparam time CYC = 20ns;

    typedef struct {
        logic [W-1:0] res;
        int           steps;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] op_p = '0;
    logic [W-1:0] op_q = '0;
    logic         done;
    logic [W-1:0] result;
    logic [W-1:0] dbg_x, dbg_y, dbg_a, dbg_b;
    logic         dbg_c, dbg_s;

    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;
    exp_t sb_q[$];

    always #(CYC/2) clk = ~clk;

    gcd_lockstep #(.W(W)) uut (
        .clk(clk), .rst(rst), .start(start), .op_p(op_p), .op_q(op_q),
        .done(done), .result(result),
        .dbg_x(dbg_x), .dbg_y(dbg_y), .dbg_c(dbg_c),
        .dbg_a(dbg_a), .dbg_b(dbg_b), .dbg_s(dbg_s)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // driver: model the single-engine rule, push expectation, pulse start
    task automatic launch(input logic [W-1:0] p, input logic [W-1:0] q);
        exp_t e;
        logic [W-1:0] m0 = p;
        logic [W-1:0] m1 = q;
        int n = 0;
        logic [W-1:0] t;
        while (m0 != m1) begin
            if (m0 < m1) begin t = m0; m0 = m1; m1 = t; end
            else m0 = m0 - m1;
            n++;
        end
        e.res = m0;
        e.steps = n;
        sb_q.push_back(e);
        op_p = p;
        op_q = q;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    // monitor: pops expectations and compares cycle count and result (R9, R5)
    always begin
        @(posedge clk);
        if (!rst && start) begin
            exp_t e;
            int k;
            bit active;
            e = sb_q.pop_front();
            k = 0;
            active = 1;
            while (active) begin
                @(negedge clk);
                if (done) begin
                    check(k == e.steps, "R9", "cycles to done", k, e.steps);
                    check(result == e.res, "R5", "result", result, e.res);
                    active = 0;
                end else begin
                    @(posedge clk);
                    if (start) begin
                        e = sb_q.pop_front();
                        k = 0;
                    end else k++;
                end
            end
        end
    end

    // every-cycle mapping check between the two engines (R4)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(dbg_a == (dbg_c ? dbg_y : dbg_x), "R4", "mapped first", dbg_a,
                  dbg_c ? dbg_y : dbg_x);
            check(dbg_b == (dbg_c ? dbg_x : dbg_y), "R4", "mapped second", dbg_b,
                  dbg_c ? dbg_x : dbg_y);
            check(dbg_s == dbg_c, "R4", "history vs orientation", dbg_s, dbg_c);
        end
    end

    initial begin
        #(CYC * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] xs[5] = '{4, 4, 4, 4, 2};
        logic [W-1:0] ys[5] = '{6, 6, 2, 2, 2};
        logic         cs[5] = '{0, 1, 1, 0, 0};
        logic [W-1:0] as_[5] = '{4, 6, 2, 4, 2};
        logic [W-1:0] bs[5] = '{6, 4, 4, 2, 2};
        logic [W-1:0] hold_r;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R5 reset state
        check(done == 1'b0, "R5", "done after reset", done, 0);
        check(result == '0 && dbg_x == '0 && dbg_y == '0 && dbg_a == '0 &&
              dbg_b == '0 && !dbg_c && !dbg_s, "R5", "state after reset", result, 0);

        // R1, R7, R8: 4 and 6 traced cycle by cycle
        launch(16'd4, 16'd6);
        check(dbg_x == 4 && dbg_a == 4 && dbg_y == 6 && dbg_b == 6 && !dbg_c && !dbg_s,
              "R1", "loaded tuple", dbg_x, 4);
        for (int i = 0; i < 5; i++) begin
            check(dbg_x == xs[i] && dbg_y == ys[i] && dbg_c == cs[i], "R7",
                  $sformatf("paired tuple step %0d x", i), dbg_x, xs[i]);
            check(dbg_a == as_[i] && dbg_b == bs[i] && dbg_s == cs[i], "R8",
                  $sformatf("single tuple step %0d a", i), dbg_a, as_[i]);
            if (i < 4) @(negedge clk);
        end
        check(done == 1'b1, "R5", "done at end of 4,6", done, 1);

        // R6: result and state hold after done
        hold_r = result;
        repeat (3) @(negedge clk);
        check(done == 1'b1 && result == hold_r && dbg_x == 2 && dbg_y == 2,
              "R6", "held result", result, hold_r);

        // R2, R3: reversed order, no initial exchange
        launch(16'd6, 16'd4);
        check(dbg_a == 6 && dbg_b == 4, "R1", "loaded reversed", dbg_a, 6);
        @(negedge clk);
        check(dbg_a == 2 && dbg_b == 4 && !dbg_s, "R2", "reduce first value", dbg_a, 2);
        check(dbg_x == 2 && dbg_y == 4 && !dbg_c, "R3", "reduce larger value", dbg_x, 2);
        @(negedge clk);
        check(dbg_a == 4 && dbg_b == 2 && dbg_s, "R2", "exchange", dbg_a, 4);
        check(dbg_x == 2 && dbg_y == 4 && dbg_c, "R3", "pause with flip", dbg_c, 1);
        wait_done();

        // R9: equal operands finish on the first cycle
        launch(16'd7, 16'd7);
        check(done == 1'b1 && result == 7, "R9", "equal operands immediate", done, 1);

        launch(16'd12, 16'd18);
        wait_done();
        launch(16'd35, 16'd64);
        wait_done();
        launch(16'd65535, 16'd65535);
        wait_done();
        launch(16'd1, 16'd9);
        wait_done();

        // R1: restart in the middle of a long run
        launch(16'd2000, 16'd1);
        repeat (10) @(negedge clk);
        check(done == 1'b0, "R1", "long run still busy", done, 0);
        launch(16'd9, 16'd6);
        wait_done();
        check(result == 3, "R1", "restart result", result, 3);

        launch(16'd3000, 16'd7);
        wait_done();
        repeat (2) @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule